// File: doc/BRIEF.md
# Two-Wire EEPROM Target Controller

This block is the target side of an I2C serial EEPROM. It holds a byte array whose size is set by a parameter, from 128 bytes to 2 KB. The array is built from internal registers. SCL and SDA reach the block already synchronised to a fast system clock. The block drives the bus only through an open-drain pull-low output.

A transfer opens with a start condition. The first byte is a device select byte carrying a type code, chip-enable bits and a direction bit. When that byte matches, the block serves one of four transfers:
- a current-address read;
- a random read (a write select, an address byte, then a repeated start and a read select);
- a sequential read, which runs for as long as the controller acknowledges each byte;
- a byte write or a page write.

An internal address counter keeps its value between transfers. On larger arrays, the upper address bits travel in the chip-enable positions of the select byte.

Write data goes into a page buffer first. A stop condition commits it to the array, and the commit takes a fixed number of system clocks. Throughout that write cycle the block ignores the bus entirely. A write-control input, held high, blocks every write.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins reception of a select byte, both from standby and in the middle of a transfer. A stop condition (SDA rising while SCL is high) returns the block to standby. In standby, bytes clocked without a start get no acknowledge.
- R2: The block acknowledges a select byte by pulling SDA low during the ninth clock only when both of these hold:
  - select bits 7..4 equal 1010;
  - every compared chip-enable bit (select bits 3..1, against strap inputs 2..0) matches.
  On a mismatch it does not acknowledge, and it acknowledges nothing further until the next start.
- R3: Select bit 1 carries address bit 8 and is not compared when the array has more than 256 bytes. The same rule applies to select bit 2 with address bit 9 (more than 512 bytes) and select bit 3 with address bit 10 (2 KB). The default array is 512 bytes.
- R4: A random read returns the addressed byte MSB first. The block changes its SDA drive only while SCL is low.
- R5: A sequential read delivers consecutive bytes while the controller acknowledges. The address wraps from the top of the array to 0.
- R6: The address counter points one past the last byte transferred and keeps that value across transfers. A current-address read (read select only) returns the byte at the counter.
- R7: A write reaches the array only after a stop that ends a write transfer with at least one accepted data byte. The stop raises `writeBusy` for exactly WRITE_CYCLES system clocks. A repeated start instead of a stop discards the pending data.
- R8: While `writeBusy` is high the block never pulls SDA low and does not answer a select byte.
- R9: A page write wraps its address within the current 16-byte page. The 17th data byte overwrites the first.
- R10: While `wrLock` is high, the address byte of a write is acknowledged but data bytes are not. No write cycle starts and the array is unchanged.
- R11: After reset the block releases SDA, `writeBusy` is low, and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised serial clock from the bus |
| sdaIn | input | 1 | Synchronised serial data as seen on the bus |
| strapCe | input | 3 | Chip-enable strap inputs |
| wrLock | input | 1 | Write control; high blocks all writes |
| sdaPullLow | output | 1 | High pulls SDA low (open-drain drive) |
| writeBusy | output | 1 | Internal write cycle in progress |

## Verification
A wrong bit counter or wrong state shows up within one byte time. It appears as an acknowledge in the wrong clock, or a missing one, or a read byte shifted by a bit position. A corrupt address counter or page index stays invisible until a later read returns data from the wrong location. For that reason every write is followed by reads of the written bytes and of their neighbours, including across the page and array wrap points. A mistimed commit appears only through the length of `writeBusy` and through whether a select byte sent during the cycle gets an acknowledge.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  // Strobes from the bus controller to the datapath, one system clock wide
  typedef struct packed {
    logic shiftIn;    // capture one received bit
    logic selWrite;   // write select accepted: keep its upper address bits
    logic loadAddr;   // address byte complete: load the counter
    logic storeByte;  // data byte accepted: put it into the page buffer
    logic loadTx;     // fetch the next read byte and advance the counter
    logic commit;     // stop after accepted write data: start the write cycle
  } dpStrobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sdaIn,
  input  dpStrobe_t strobe,
  output logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic      busy
);
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int PAGE_W  = $clog2(PAGE_BYTES);
  localparam int HI_W    = (ADDR_W > 8) ? ADDR_W - 8 : 1;
  localparam int TIMER_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]            mem     [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0]     addr, addrLoad;
  logic [HI_W-1:0]       selHi;
  logic [TIMER_W-1:0]    timer;
  logic [PAGE_W-1:0]     pageIdx;
  logic                  commitNow;

  assign pageIdx   = addr[PAGE_W-1:0];
  assign busy      = (timer != '0);
  assign commitNow = (timer == TIMER_W'(1));

  // Upper address bits come from the select byte only on arrays above 256 bytes
  generate
    if (ADDR_W > 8) begin : g_wideAddr
      assign addrLoad = {selHi, rxByte};
    end else begin : g_narrowAddr
      assign addrLoad = rxByte[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte    <= '0;
      txByte    <= '0;
      addr      <= '0;
      selHi     <= '0;
      pageValid <= '0;
      timer     <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaIn};
      if (strobe.selWrite) selHi <= rxByte[HI_W:1];

      if (strobe.loadAddr) begin
        addr      <= addrLoad;
        pageValid <= '0;
      end else if (strobe.storeByte) begin
        pageValid[pageIdx] <= 1'b1;
        addr <= {addr[ADDR_W-1:PAGE_W], pageIdx + 1'b1};  // stays in the page
      end else if (strobe.loadTx) begin
        txByte <= mem[addr];
        addr   <= addr + 1'b1;                             // wraps at array top
      end

      if (strobe.commit) timer <= TIMER_W'(WRITE_CYCLES);
      else if (busy)     timer <= timer - 1'b1;
      if (commitNow) pageValid <= '0;
    end
  end

  // Array and page buffer have no reset
  always_ff @(posedge clk) begin
    if (strobe.storeByte) pageBuf[pageIdx] <= rxByte;
    if (commitNow) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageValid[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

endmodule

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapCe,
  input  logic       wrLock,
  input  logic [7:0] rxByte,
  input  logic [7:0] txByte,
  input  logic       busy,
  output dpStrobe_t  strobe,
  output logic       sdaPullLow
);
  // A chip-enable bit is compared only when it does not carry an address bit
  localparam logic [2:0] CE_MASK = {ADDR_W <= 10, ADDR_W <= 9, ADDR_W <= 8};

  busState_t  state;
  logic [3:0] bitCnt;      // SCL rising edges in the current byte, 9 = ack clock seen
  logic [2:0] txIdx;
  logic       sclQ, sdaQ, ackDrive, txEn, masterAck, pending;
  logic       sclRise, sclFall, startEv, stopEv, active, rxState, selMatch;

  always_comb begin
    sclRise  = sclIn & ~sclQ;
    sclFall  = ~sclIn & sclQ;
    startEv  = sclIn & sclQ & sdaQ & ~sdaIn;
    stopEv   = sclIn & sclQ & ~sdaQ & sdaIn;
    active   = !busy && !startEv && !stopEv && (state != ST_IDLE);
    rxState  = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_WDATA);
    selMatch = (rxByte[7:4] == DEV_TYPE) && (((rxByte[3:1] ^ strapCe) & CE_MASK) == 3'b000);
  end

  always_comb begin
    strobe         = '0;
    strobe.shiftIn = active && sclRise && rxState && (bitCnt < 4'd8);
    if (active && sclFall && bitCnt == 4'd8) begin
      case (state)
        ST_SEL:   strobe.selWrite  = selMatch && !rxByte[0];
        ST_ADDR:  strobe.loadAddr  = 1'b1;
        ST_WDATA: strobe.storeByte = !wrLock;
        default:  ;
      endcase
    end
    strobe.loadTx = active && sclFall && (bitCnt == 4'd9) && (state == ST_RDATA) && masterAck;
    strobe.commit = !busy && stopEv && (state == ST_WDATA) && pending;
  end

  assign sdaPullLow = ackDrive | (txEn & ~txByte[txIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      txIdx     <= 3'd7;
      ackDrive  <= 1'b0;
      txEn      <= 1'b0;
      masterAck <= 1'b0;
      pending   <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (busy) begin
        state <= ST_IDLE;                    // bus ignored during the write cycle
      end else if (startEv || stopEv) begin
        state    <= startEv ? ST_SEL : ST_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
        pending  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 1'b1;
          // in a read this samples the controller's ack (own ack after the select)
          if (bitCnt == 4'd8 && state == ST_RDATA) masterAck <= ~sdaIn;
        end
        if (sclFall) begin
          if (bitCnt == 4'd8) begin
            case (state)
              ST_SEL: begin
                ackDrive <= selMatch;
                state    <= !selMatch ? ST_IDLE : (rxByte[0] ? ST_RDATA : ST_ADDR);
              end
              ST_ADDR: begin
                ackDrive <= 1'b1;
                state    <= ST_WDATA;
              end
              ST_WDATA: begin
                ackDrive <= !wrLock;
                pending  <= !wrLock;
                if (wrLock) state <= ST_IDLE;
              end
              default: txEn <= 1'b0;         // release for the controller's ack
            endcase
          end else if (bitCnt == 4'd9) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (state == ST_RDATA) begin
              if (masterAck) begin
                txEn  <= 1'b1;
                txIdx <= 3'd7;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else if (bitCnt != 4'd0) begin
            txIdx <= 3'd7 - bitCnt[2:0];
          end
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapCe,
  input  logic       wrLock,
  output logic       sdaPullLow,
  output logic       writeBusy
);
  localparam int ADDR_W = $clog2(MEM_BYTES);

  dpStrobe_t  strobe;
  logic [7:0] rxByte, txByte;

  eeprom_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapCe   (strapCe),
    .wrLock    (wrLock),
    .rxByte    (rxByte),
    .txByte    (txByte),
    .busy      (writeBusy),
    .strobe    (strobe),
    .sdaPullLow(sdaPullLow)
  );

  eeprom_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .sdaIn (sdaIn),
    .strobe(strobe),
    .rxByte(rxByte),
    .txByte(txByte),
    .busy  (writeBusy)
  );

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk #(
  parameter int WRITE_CYCLES = 500
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaPullLow,
  input logic writeBusy
);
  int busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)          busyLen <= 0;
    else if (writeBusy) busyLen <= busyLen + 1;
    else                busyLen <= 0;
  end

  // R11: bus released on the first cycle out of reset
  p_reset_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !sdaPullLow && !writeBusy);

  // R8: no drive at all during the write cycle
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |-> !sdaPullLow);

  // R4: drive changes only while SCL is low
  p_sda_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullLow));

  // R7: write cycle length
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> busyLen == WRITE_CYCLES);

  // R7: write cycle starts only right after a stop condition
  p_busy_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(writeBusy) |-> $past(sclIn) && $past(sdaIn) && !$past(sdaIn, 2));

endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaIn     (sdaIn),
  .sdaPullLow(sdaPullLow),
  .writeBusy (writeBusy)
);

// File: tb/tb_eeprom_i2c_target.sv
`timescale 1ns/1ps
module tb_eeprom_i2c_target;
  localparam int MEM = 512;
  localparam int Q   = 5;     // system clocks per quarter bit

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, wrLock = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sdaPullLow, writeBusy, sdaBus;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [MEM];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  assign sdaBus = sdaM & ~sdaPullLow;
  always #2 clk = ~clk;

  eeprom_i2c_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapCe(strap),
    .wrLock(wrLock), .sdaPullLow(sdaPullLow), .writeBusy(writeBusy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); ack = !sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaBus; waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = !giveAck; waitQ(); sclM = 1'b1; waitQ(2); sclM = 1'b0; waitQ(); sdaM = 1'b1;
  endtask

  function automatic logic [7:0] selCode(input logic rw, input int addr);
    logic [10:0] a = 11'(addr);
    return {4'b1010, strap[2:1], a[8], rw};
  endfunction

  task automatic waitIdle();
    while (writeBusy) @(negedge clk);
    waitQ();
  endtask

  // write n bytes of wbuf; model follows the page roll-over rule
  task automatic writeBlock(input int addr, input int n, output logic allAck);
    logic ack;
    i2cStart();
    sendByte(selCode(1'b0, addr), ack); allAck = ack;
    sendByte(8'(addr), ack);            allAck &= ack;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], ack); allAck &= ack;
    end
    i2cStop();
    if (allAck) for (int k = 0; k < n; k++) model[(addr & ~15) + ((addr + k) & 15)] = wbuf[k];
  endtask

  task automatic randomRead(input int addr, input int n);
    logic ack;
    i2cStart();
    sendByte(selCode(1'b0, addr), ack);
    sendByte(8'(addr), ack);
    i2cStart();
    sendByte(selCode(1'b1, addr), ack);
    for (int k = 0; k < n; k++) readByte(k != n - 1, rbuf[k]);
    i2cStop();
  endtask

  task automatic testReset();
    check("R11 sda released", sdaPullLow, 0);
    check("R11 busy low", writeBusy, 0);
  endtask

  task automatic testByteWrite();
    logic ok;
    wbuf[0] = 8'h3C;
    writeBlock(5, 1, ok);
    check("R2 write acks", ok, 1);
    check("R7 busy after stop", writeBusy, 1);
    waitIdle();
    randomRead(5, 1);
    check("R4 random read", rbuf[0], 8'h3C);
  endtask

  task automatic testHighAddr();
    logic ok;
    wbuf[0] = 8'hA5;
    writeBlock(12'h105, 1, ok);
    check("R3 upper write acked", ok, 1);
    waitIdle();
    randomRead(12'h105, 1);
    check("R3 read 0x105", rbuf[0], 8'hA5);
    randomRead(5, 1);
    check("R3 0x005 intact", rbuf[0], 8'h3C);
  endtask

  task automatic testMismatch();
    logic ack;
    i2cStart();
    sendByte({4'b1010, ~strap[2], strap[1], 1'b0, 1'b0}, ack);
    check("R2 ce mismatch nack", ack, 0);
    sendByte(8'h00, ack);
    check("R2 ignored after mismatch", ack, 0);
    i2cStop();
    i2cStart();
    sendByte({4'b1011, strap[2:1], 1'b0, 1'b1}, ack);
    check("R2 type mismatch nack", ack, 0);
    i2cStop();
  endtask

  task automatic testStandby();
    logic ack;
    sendByte(selCode(1'b1, 0), ack);
    check("R1 no start no ack", ack, 0);
    i2cStop();
    i2cStart();
    sendByte(selCode(1'b1, 0), ack);
    check("R1 start then ack", ack, 1);
    readByte(1'b0, rbuf[0]);
    i2cStop();
  endtask

  task automatic testPageCurrent();
    logic ok, ack;
    for (int k = 0; k < 16; k++) wbuf[k] = 8'(k * 3 + 1);
    writeBlock(0, 16, ok);
    check("R9 page acks", ok, 1);
    waitIdle();
    randomRead(5, 1);
    check("R6 read 0x005", rbuf[0], model[5]);
    i2cStart();
    sendByte(selCode(1'b1, 0), ack);
    readByte(1'b0, rbuf[0]);
    i2cStop();
    check("R6 current address read", rbuf[0], model[6]);
    randomRead(0, 4);
    for (int k = 0; k < 4; k++) check("R5 sequential read", rbuf[k], model[k]);
  endtask

  task automatic testWrap();
    logic ok;
    wbuf[0] = 8'hEE;
    writeBlock(12'h1FF, 1, ok);
    waitIdle();
    randomRead(12'h1FF, 2);
    check("R5 top byte", rbuf[0], 8'hEE);
    check("R5 wrap to 0", rbuf[1], model[0]);
  endtask

  task automatic testRollover();
    logic ok;
    for (int k = 0; k < 17; k++) wbuf[k] = 8'(8'h80 + k);
    writeBlock(12'h0FE, 17, ok);
    waitIdle();
    check("R9 first byte overwritten", model[12'h0FE], 8'h90);
    randomRead(12'h0F0, 16);
    for (int k = 0; k < 16; k++) check("R9 page roll-over", rbuf[k], model[12'h0F0 + k]);
  endtask

  task automatic testLock();
    logic ack;
    wrLock = 1'b1;
    i2cStart();
    sendByte(selCode(1'b0, 5), ack);
    sendByte(8'h05, ack);
    check("R10 address acked", ack, 1);
    sendByte(8'h99, ack);
    check("R10 data nack", ack, 0);
    i2cStop();
    check("R10 no write cycle", writeBusy, 0);
    wrLock = 1'b0;
    randomRead(5, 1);
    check("R10 array unchanged", rbuf[0], model[5]);
  endtask

  task automatic testNoStop();
    logic ack;
    i2cStart();
    sendByte(selCode(1'b0, 7), ack);
    sendByte(8'h07, ack);
    sendByte(8'h55, ack);
    check("R7 data acked", ack, 1);
    i2cStart();
    i2cStop();
    check("R7 no cycle without stop", writeBusy, 0);
    randomRead(7, 1);
    check("R7 pending discarded", rbuf[0], model[7]);
  endtask

  task automatic testBusyIgnore();
    logic ok, ack;
    wbuf[0] = 8'h11;
    writeBlock(12'h030, 1, ok);
    i2cStart();
    sendByte(selCode(1'b1, 0), ack);
    check("R8 busy still high", writeBusy, 1);
    check("R8 select ignored", ack, 0);
    i2cStop();
    waitIdle();
    randomRead(12'h030, 1);
    check("R8 write committed", rbuf[0], 8'h11);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    testReset();
    testByteWrite();
    testHighAddr();
    testMismatch();
    testStandby();
    testPageCurrent();
    testWrap();
    testRollover();
    testLock();
    testNoStop();
    testBusyIgnore();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule